// File: doc/BRIEF.md
# Channel Half-Word Byte Assembler

This block sits between a peripheral data channel and a memory port that works in 16-bit half-words. In the inbound direction it collects bytes from the channel and packs them into half-words. In the outbound direction it takes half-words and splits them into bytes for the channel. A 3-bit format code sets both the byte width (a quarter, half or all of the half-word) and the number of bytes in each half-word. One format yields three 4-bit bytes with the low nibble left empty.

Static control inputs set the direction and the half (left or right) addressed first. They also set whether successive half-words alternate between halves and whether an exec flag travels with each word. Every byte carries a parity bit. Parity is odd when binary mode is selected and even otherwise. The block generates parity on outbound bytes and checks it on inbound bytes, holding any mismatch in a sticky flag. Both the byte side and the half-word side use valid/ready handshakes. A transfer is accepted on a clock edge where valid and ready are both high.

Top module: `bhw_assembler`

## Requirements
- R1: The format code selects byte width W and count N per half-word: 001 gives W=8,N=1; 010 gives W=8,N=2; 011 gives W=16,N=1; 100 gives W=4,N=4; 101 gives W=4,N=1; 110 gives W=4,N=2; 111 gives W=4,N=3. Byte k of a half-word (k from 0) occupies bits [15-W*k : 16-W*(k+1)], so packing starts at the most significant end.
- R2: Half-word bits below the last byte slot are zero in an inbound half-word. With code 111, bits [3:0] are zero.
- R3: Format code 000 is idle. All ready and valid outputs stay low, partial state is discarded, and cur_half is reloaded from start_half.
- R4: With dir_in=1, bytes flow from ch_in_* to mem_wr_*, and mem_rd_ready and ch_out_valid stay low. With dir_in=0, half-words flow from mem_rd_* to ch_out_*, and ch_in_ready and mem_wr_valid stay low.
- R5: Outbound bytes are taken from the half-word most significant slot first. mem_rd_ready stays low until the last byte of the held half-word has been accepted, and a byte stays valid and stable until accepted.
- R6: An inbound half-word is presented on mem_wr_* only after its N-th byte has been accepted. It stays valid and stable until accepted.
- R7: cur_half (0 = left, 1 = right) names the half of the current half-word transfer. It starts at start_half and toggles after each half-word handshake when alt_en=1. It stays constant when alt_en=0.
- R8: Inbound, the ch_in_exec value of the first byte of a half-word is reported on mem_wr_exec. Outbound, mem_rd_exec is repeated on ch_out_exec for every byte of that half-word. Both outputs are 0 when exec_en=0.
- R9: ch_out_par makes the count of ones over the W data bits plus the parity bit odd when bin_mode=1 and even when bin_mode=0.
- R10: An accepted inbound byte whose parity does not match the R9 rule sets par_err. par_err then stays set until err_clr is high at a clock edge. If a mismatch and err_clr arrive at the same edge, the flag is set.
- R11: Bits of ch_in_data above the byte width are ignored for both data and parity. Bits of ch_out_data above the byte width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 3 | Format code (000 = idle) |
| dir_in | input | 1 | 1: channel to memory, 0: memory to channel |
| start_half | input | 1 | First half addressed (0 left, 1 right) |
| alt_en | input | 1 | Alternate halves after each half-word |
| exec_en | input | 1 | Exec flag carried with each word |
| bin_mode | input | 1 | 1: odd parity (binary), 0: even parity (BCD) |
| err_clr | input | 1 | Clears the parity error flag |
| ch_in_valid | input | 1 | Inbound byte valid |
| ch_in_ready | output | 1 | Inbound byte ready |
| ch_in_data | input | 16 | Inbound byte, right-aligned |
| ch_in_par | input | 1 | Inbound byte parity bit |
| ch_in_exec | input | 1 | Inbound exec flag |
| mem_wr_valid | output | 1 | Packed half-word valid |
| mem_wr_ready | input | 1 | Packed half-word ready |
| mem_wr_data | output | 16 | Packed half-word |
| mem_wr_exec | output | 1 | Exec flag of packed half-word |
| mem_rd_valid | input | 1 | Half-word to unpack valid |
| mem_rd_ready | output | 1 | Half-word to unpack ready |
| mem_rd_data | input | 16 | Half-word to unpack |
| mem_rd_exec | input | 1 | Exec flag of half-word to unpack |
| ch_out_valid | output | 1 | Outbound byte valid |
| ch_out_ready | input | 1 | Outbound byte ready |
| ch_out_data | output | 16 | Outbound byte, right-aligned |
| ch_out_par | output | 1 | Outbound byte parity bit |
| ch_out_exec | output | 1 | Outbound exec flag |
| cur_half | output | 1 | Half addressed by the current transfer |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The assertions check on every cycle the handshake rules that hold regardless of data:
- a waiting half-word or byte stays stable;
- the idle code and the inactive direction keep their side quiet;
- cur_half stays fixed when alternation is off;
- the error flag stays set and rises only after an accepted byte;
- the low nibble is empty in the three-nibble format.

Only the bench scenarios can show that bytes land in the correct slot for each format code and come out in the correct order. The same holds for the parity sense following the mode, the exec flag going with the correct word, and the error flag winning over a simultaneous clear.

// File: rtl/bhw_pkg.sv
package bhw_pkg;
   localparam logic [1:0] W_QTR  = 2'd0;
   localparam logic [1:0] W_HALF = 2'd1;
   localparam logic [1:0] W_FULL = 2'd2;

   typedef struct packed {
      logic       idle;
      logic [1:0] wsel;   // byte width class
      logic [1:0] last;   // bytes per half-word minus one
   } fmt_t;

   function automatic fmt_t fmt_decode(input logic [2:0] code);
      fmt_t r;
      r = '{idle: 1'b0, wsel: W_HALF, last: 2'd0};
      case (code)
         3'b000: r.idle = 1'b1;
         3'b001: begin r.wsel = W_HALF; r.last = 2'd0; end
         3'b010: begin r.wsel = W_HALF; r.last = 2'd1; end
         3'b011: begin r.wsel = W_FULL; r.last = 2'd0; end
         3'b100: begin r.wsel = W_QTR;  r.last = 2'd3; end
         3'b101: begin r.wsel = W_QTR;  r.last = 2'd0; end
         3'b110: begin r.wsel = W_QTR;  r.last = 2'd1; end
         default: begin r.wsel = W_QTR; r.last = 2'd2; end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/bhw_lane.sv
module bhw_lane #(
   parameter int HW_W = 16,
   localparam int SH_W = $clog2(HW_W + 1)
) (
   input  logic [1:0]      wsel,
   input  logic [1:0]      slot,
   output logic [HW_W-1:0] mask,
   output logic [SH_W-1:0] shamt
);
   import bhw_pkg::*;

   logic [SH_W-1:0] bw;
   int              s_i;

   always_comb begin
      case (wsel)
         W_QTR:   bw = SH_W'(HW_W / 4);
         W_HALF:  bw = SH_W'(HW_W / 2);
         default: bw = SH_W'(HW_W);
      endcase
      s_i = HW_W - int'(bw) * (int'(slot) + 1);
      if (s_i < 0) s_i = 0;
      shamt = SH_W'(s_i);
   end

   for (genvar i = 0; i < HW_W; i++) begin : g_mask
      assign mask[i] = (SH_W'(i) < bw);
   end
endmodule

// File: rtl/bhw_parity.sv
module bhw_parity #(
   parameter int HW_W = 16
) (
   input  logic [HW_W-1:0] data,
   input  logic [HW_W-1:0] mask,
   output logic            xsum
);
   logic [HW_W-1:0] sel;

   for (genvar i = 0; i < HW_W; i++) begin : g_sel
      assign sel[i] = data[i] & mask[i];
   end

   assign xsum = ^sel;
endmodule

// File: rtl/bhw_pack.sv
module bhw_pack #(
   parameter int HW_W = 16,
   localparam int SH_W = $clog2(HW_W + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic [1:0]      wsel,
   input  logic [1:0]      last,
   input  logic            odd_mode,
   input  logic            err_clr,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [HW_W-1:0] in_data,
   input  logic            in_par,
   input  logic            in_exec,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [HW_W-1:0] out_data,
   output logic            out_exec,
   output logic            par_err
);
   import bhw_pkg::*;

   logic [1:0]      cnt;
   logic [HW_W-1:0] acc;
   logic            full, exec_q, err_q;
   logic [HW_W-1:0] mask;
   logic [SH_W-1:0] shamt;
   logic            xsum, bad, accept;
   logic [HW_W-1:0] placed;

   bhw_lane #(.HW_W(HW_W)) u_lane (
      .wsel(wsel), .slot(cnt), .mask(mask), .shamt(shamt));

   bhw_parity #(.HW_W(HW_W)) u_chk (
      .data(in_data), .mask(mask), .xsum(xsum));

   assign bad      = ((xsum ^ in_par) != odd_mode);
   assign in_ready = active && !full;
   assign accept   = in_valid && in_ready;
   assign placed   = (in_data & mask) << shamt;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         cnt    <= '0;
         acc    <= '0;
         full   <= 1'b0;
         exec_q <= 1'b0;
      end else begin
         if (accept) begin
            acc <= ((cnt == 2'd0) ? '0 : acc) | placed;
            if (cnt == 2'd0) exec_q <= in_exec;
            if (cnt == last) begin
               cnt  <= '0;
               full <= 1'b1;
            end else begin
               cnt <= cnt + 2'd1;
            end
         end
         if (out_valid && out_ready) full <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              err_q <= 1'b0;
      else if (accept && bad)  err_q <= 1'b1;
      else if (err_clr)        err_q <= 1'b0;
   end

   assign out_valid = full;
   assign out_data  = acc;
   assign out_exec  = exec_q;
   assign par_err   = err_q;

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && active) |=> (out_valid && $stable(out_data))); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err && !err_clr) |=> par_err); // R10
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> $past(in_valid && in_ready)); // R10
   AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wsel == W_QTR && last == 2'd2) |-> (out_data[HW_W/4-1:0] == '0)); // R2
endmodule

// File: rtl/bhw_unpack.sv
module bhw_unpack #(
   parameter int HW_W = 16,
   localparam int SH_W = $clog2(HW_W + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic [1:0]      wsel,
   input  logic [1:0]      last,
   input  logic            odd_mode,
   input  logic            rd_valid,
   output logic            rd_ready,
   input  logic [HW_W-1:0] rd_data,
   input  logic            rd_exec,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [HW_W-1:0] out_data,
   output logic            out_par,
   output logic            out_exec
);
   logic [1:0]      cnt;
   logic [HW_W-1:0] hold_q;
   logic            have, exec_q, xsum;
   logic [HW_W-1:0] mask;
   logic [SH_W-1:0] shamt;

   bhw_lane #(.HW_W(HW_W)) u_lane (
      .wsel(wsel), .slot(cnt), .mask(mask), .shamt(shamt));

   assign out_data = (hold_q >> shamt) & mask;

   bhw_parity #(.HW_W(HW_W)) u_gen (
      .data(out_data), .mask(mask), .xsum(xsum));

   assign out_par   = xsum ^ odd_mode;
   assign rd_ready  = active && !have;
   assign out_valid = have;
   assign out_exec  = exec_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         cnt    <= '0;
         hold_q <= '0;
         have   <= 1'b0;
         exec_q <= 1'b0;
      end else if (rd_valid && rd_ready) begin
         hold_q <= rd_data;
         exec_q <= rd_exec;
         have   <= 1'b1;
         cnt    <= '0;
      end else if (out_valid && out_ready) begin
         if (cnt == last) begin
            have <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 2'd1;
         end
      end
   end

   AST_RD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> (out_valid || !active)); // R5
   AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && active) |=> (out_valid && $stable(out_data))); // R5
endmodule

// File: rtl/bhw_assembler.sv
module bhw_assembler #(
   parameter int HW_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      fmt,
   input  logic            dir_in,
   input  logic            start_half,
   input  logic            alt_en,
   input  logic            exec_en,
   input  logic            bin_mode,
   input  logic            err_clr,
   input  logic            ch_in_valid,
   output logic            ch_in_ready,
   input  logic [HW_W-1:0] ch_in_data,
   input  logic            ch_in_par,
   input  logic            ch_in_exec,
   output logic            mem_wr_valid,
   input  logic            mem_wr_ready,
   output logic [HW_W-1:0] mem_wr_data,
   output logic            mem_wr_exec,
   input  logic            mem_rd_valid,
   output logic            mem_rd_ready,
   input  logic [HW_W-1:0] mem_rd_data,
   input  logic            mem_rd_exec,
   output logic            ch_out_valid,
   input  logic            ch_out_ready,
   output logic [HW_W-1:0] ch_out_data,
   output logic            ch_out_par,
   output logic            ch_out_exec,
   output logic            cur_half,
   output logic            par_err
);
   import bhw_pkg::*;

   if (HW_W % 4 != 0 || HW_W < 8) begin : g_bad_width
      $error("bhw_assembler: HW_W must be a multiple of 4 and at least 8");
   end

   fmt_t f;
   logic in_act, out_act, pk_exec, up_exec, half_q, hw_done;

   assign f       = fmt_decode(fmt);
   assign in_act  = !f.idle && dir_in;
   assign out_act = !f.idle && !dir_in;

   bhw_pack #(.HW_W(HW_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .active(in_act), .wsel(f.wsel), .last(f.last),
      .odd_mode(bin_mode), .err_clr(err_clr),
      .in_valid(ch_in_valid), .in_ready(ch_in_ready), .in_data(ch_in_data),
      .in_par(ch_in_par), .in_exec(ch_in_exec),
      .out_valid(mem_wr_valid), .out_ready(mem_wr_ready), .out_data(mem_wr_data),
      .out_exec(pk_exec), .par_err(par_err));

   bhw_unpack #(.HW_W(HW_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .active(out_act), .wsel(f.wsel), .last(f.last),
      .odd_mode(bin_mode),
      .rd_valid(mem_rd_valid), .rd_ready(mem_rd_ready), .rd_data(mem_rd_data),
      .rd_exec(mem_rd_exec),
      .out_valid(ch_out_valid), .out_ready(ch_out_ready), .out_data(ch_out_data),
      .out_par(ch_out_par), .out_exec(up_exec));

   assign mem_wr_exec = pk_exec & exec_en;
   assign ch_out_exec = up_exec & exec_en;

   assign hw_done = (mem_wr_valid && mem_wr_ready) || (mem_rd_valid && mem_rd_ready);

   always_ff @(posedge clk) begin
      if (!rst_n)                  half_q <= 1'b0;
      else if (f.idle)             half_q <= start_half;
      else if (hw_done && alt_en)  half_q <= ~half_q;
   end

   assign cur_half = half_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == 3'b000 && $past(fmt == 3'b000))
      |-> (!mem_wr_valid && !ch_out_valid && !ch_in_ready && !mem_rd_ready)); // R3
   AST_DIR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!f.idle && dir_in && $past(dir_in)) |-> (!mem_rd_ready && !ch_out_valid)); // R4
   AST_HALF_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (!alt_en && !f.idle && $past(!alt_en && !f.idle)) |-> $stable(cur_half)); // R7
endmodule

// File: tb/bhw_assembler_test.sv
module bhw_assembler_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  fmt = 3'b000;
   logic        dir_in = 1'b1, start_half = 1'b0, alt_en = 1'b0;
   logic        exec_en = 1'b0, bin_mode = 1'b1, err_clr = 1'b0;
   logic        ch_in_valid = 1'b0, ch_in_par = 1'b0, ch_in_exec = 1'b0;
   logic [15:0] ch_in_data = '0;
   logic        ch_in_ready;
   logic        mem_wr_valid, mem_wr_exec;
   logic        mem_wr_ready = 1'b0;
   logic [15:0] mem_wr_data;
   logic        mem_rd_valid = 1'b0, mem_rd_exec = 1'b0;
   logic [15:0] mem_rd_data = '0;
   logic        mem_rd_ready;
   logic        ch_out_valid, ch_out_par, ch_out_exec;
   logic        ch_out_ready = 1'b0;
   logic [15:0] ch_out_data;
   logic        cur_half, par_err;

   int nchk = 0;
   int nerr = 0;

   logic [15:0] byt [0:63];
   bit          bex [0:63];
   logic [15:0] wrd [0:15];
   bit          wex [0:15];

   always #2 clk = ~clk;

   bhw_assembler uut (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .dir_in(dir_in), .start_half(start_half),
      .alt_en(alt_en), .exec_en(exec_en), .bin_mode(bin_mode), .err_clr(err_clr),
      .ch_in_valid(ch_in_valid), .ch_in_ready(ch_in_ready), .ch_in_data(ch_in_data),
      .ch_in_par(ch_in_par), .ch_in_exec(ch_in_exec),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
      .mem_wr_exec(mem_wr_exec),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
      .mem_rd_exec(mem_rd_exec),
      .ch_out_valid(ch_out_valid), .ch_out_ready(ch_out_ready), .ch_out_data(ch_out_data),
      .ch_out_par(ch_out_par), .ch_out_exec(ch_out_exec),
      .cur_half(cur_half), .par_err(par_err));

   function automatic int bw_of(input logic [2:0] c);
      if (c[2]) return 4;
      if (c == 3'b011) return 16;
      return 8;
   endfunction

   function automatic int n_of(input logic [2:0] c);
      case (c)
         3'b001, 3'b011, 3'b101: return 1;
         3'b010, 3'b110:         return 2;
         3'b111:                 return 3;
         3'b100:                 return 4;
         default:                return 0;
      endcase
   endfunction

   function automatic logic [15:0] mask_of(input logic [2:0] c);
      return 16'((32'h1 << bw_of(c)) - 1);
   endfunction

   function automatic logic par_of(input logic [15:0] b, input logic [2:0] c, input logic bin);
      return (^(b & mask_of(c))) ^ bin;
   endfunction

   function automatic logic [15:0] pack_exp(input logic [2:0] c, input int h);
      logic [31:0] w;
      int n, bw;
      n = n_of(c); bw = bw_of(c);
      w = '0;
      for (int k = 0; k < n; k++)
         w = w | ({16'b0, byt[h*n+k]} << (16 - bw*(k+1)));
      return w[15:0];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      fmt = 3'b000; ch_in_valid = 1'b0; mem_rd_valid = 1'b0;
      mem_wr_ready = 1'b0; ch_out_ready = 1'b0; err_clr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_in(input logic [2:0] code, input int nhw, input int bad);
      int n, total, idx, hw, cyc, viol;
      logic [15:0] m, e;
      logic half_e;
      n = n_of(code); m = mask_of(code); total = nhw * n;
      idx = 0; hw = 0; cyc = 0; viol = 0; half_e = start_half;
      for (int i = 0; i < total; i++) begin
         byt[i] = 16'($urandom) & m;
         bex[i] = bit'($urandom % 2);
      end
      fmt = code;
      while (hw < nhw && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (idx < total) begin
            ch_in_valid = (($urandom % 4) != 0);
            ch_in_data  = (16'($urandom) & ~m) | byt[idx];
            ch_in_par   = par_of(byt[idx], code, bin_mode) ^ (idx == bad);
            ch_in_exec  = bex[idx];
         end else begin
            ch_in_valid = 1'b0;
         end
         mem_wr_ready = (($urandom % 3) != 0);
         #1;
         if (mem_rd_ready || ch_out_valid) viol++;
         if (mem_wr_valid && mem_wr_ready) begin
            e = pack_exp(code, hw);
            chk("R1 packed half-word", 32'(mem_wr_data), 32'(e));
            if (code == 3'b111) chk("R2 zero fill", 32'(mem_wr_data[3:0]), 32'd0);
            chk("R6 emitted after last byte", 32'(idx >= (hw+1)*n), 32'd1);
            chk("R8 inbound exec", 32'(mem_wr_exec), 32'(bex[hw*n] & exec_en));
            chk("R7 inbound half", 32'(cur_half), 32'(half_e));
            if (alt_en) half_e = ~half_e;
            hw++;
         end
         if (ch_in_valid && ch_in_ready) idx++;
      end
      @(negedge clk);
      ch_in_valid = 1'b0; mem_wr_ready = 1'b0;
      chk("R4 outbound side quiet", 32'(viol), 32'd0);
      chk("R6 all half-words delivered", 32'(hw), 32'(nhw));
   endtask

   task automatic run_out(input logic [2:0] code, input int nhw);
      int n, bw, total, wi, bo, cyc, viol, v5, w, k;
      logic [15:0] m, e;
      logic half_e;
      n = n_of(code); bw = bw_of(code); m = mask_of(code); total = nhw * n;
      wi = 0; bo = 0; cyc = 0; viol = 0; v5 = 0; half_e = start_half;
      for (int i = 0; i < nhw; i++) begin
         wrd[i] = 16'($urandom);
         wex[i] = bit'($urandom % 2);
      end
      fmt = code;
      while (bo < total && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (wi < nhw) begin
            mem_rd_valid = (($urandom % 4) != 0);
            mem_rd_data  = wrd[wi];
            mem_rd_exec  = wex[wi];
         end else begin
            mem_rd_valid = 1'b0;
         end
         ch_out_ready = (($urandom % 3) != 0);
         #1;
         if (ch_in_ready || mem_wr_valid) viol++;
         if (mem_rd_ready && bo < wi*n) v5++;
         if (ch_out_valid && ch_out_ready) begin
            w = bo / n; k = bo % n;
            e = 16'({16'b0, wrd[w]} >> (16 - bw*(k+1))) & m;
            chk("R5 outbound byte order", 32'(ch_out_data), 32'(e));
            chk("R9 generated parity", 32'(ch_out_par), 32'(par_of(e, code, bin_mode)));
            chk("R8 outbound exec", 32'(ch_out_exec), 32'(wex[w] & exec_en));
            bo++;
         end
         if (mem_rd_valid && mem_rd_ready) begin
            chk("R7 outbound half", 32'(cur_half), 32'(half_e));
            if (alt_en) half_e = ~half_e;
            wi++;
         end
      end
      @(negedge clk);
      mem_rd_valid = 1'b0; ch_out_ready = 1'b0;
      chk("R4 inbound side quiet", 32'(viol), 32'd0);
      chk("R5 no early half-word request", 32'(v5), 32'd0);
      chk("R5 all bytes delivered", 32'(bo), 32'(total));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk("R3 reset par_err", 32'(par_err), 32'd0);
      chk("R3 reset mem_wr_valid", 32'(mem_wr_valid), 32'd0);
      chk("R3 reset ch_out_valid", 32'(ch_out_valid), 32'd0);
      chk("R7 reset half", 32'(cur_half), 32'd0);

      // R3: idle code refuses traffic on both sides and reloads the half
      @(negedge clk);
      ch_in_valid = 1'b1; mem_rd_valid = 1'b1; start_half = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk("R3 idle ch_in_ready", 32'(ch_in_ready), 32'd0);
         chk("R3 idle mem_rd_ready", 32'(mem_rd_ready), 32'd0);
      end
      chk("R3 idle reloads half", 32'(cur_half), 32'd1);
      go_idle();

      // directed: every format code in each direction
      for (int c = 1; c < 8; c++) begin
         dir_in = 1'b1; alt_en = 1'b1; exec_en = 1'b1; start_half = 1'b0; bin_mode = 1'b1;
         go_idle();
         run_in(3'(c), 3, -1);
         go_idle();
         dir_in = 1'b0; bin_mode = 1'b0; start_half = 1'b1;
         go_idle();
         run_out(3'(c), 3);
         go_idle();
      end

      // random mix of configurations
      for (int t = 0; t < 24; t++) begin
         logic [2:0] c;
         c = 3'(1 + ($urandom % 7));
         dir_in = 1'($urandom); start_half = 1'($urandom); alt_en = 1'($urandom);
         exec_en = 1'($urandom); bin_mode = 1'($urandom);
         go_idle();
         if (dir_in) run_in(c, 1 + int'($urandom % 6), -1);
         else        run_out(c, 1 + int'($urandom % 6));
         go_idle();
      end
      #1;
      chk("R11 upper bits ignored, no false parity error", 32'(par_err), 32'd0);

      // R10: injected mismatch sets the sticky flag, clear resets it
      dir_in = 1'b1; bin_mode = 1'b1; alt_en = 1'b0; exec_en = 1'b0;
      go_idle();
      run_in(3'b010, 2, 1);
      #1;
      chk("R10 mismatch sets par_err", 32'(par_err), 32'd1);
      go_idle();
      #1;
      chk("R10 par_err sticky across idle", 32'(par_err), 32'd1);
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      #1;
      chk("R10 clear resets par_err", 32'(par_err), 32'd0);

      // R10: mismatch and clear at the same edge leave the flag set
      @(negedge clk);
      fmt = 3'b001; ch_in_valid = 1'b1; ch_in_data = 16'hA50F;
      ch_in_par = ~par_of(16'h000F, 3'b001, 1'b1); err_clr = 1'b1; mem_wr_ready = 1'b0;
      @(negedge clk);
      ch_in_valid = 1'b0; err_clr = 1'b0;
      #1;
      chk("R10 set wins over clear", 32'(par_err), 32'd1);
      chk("R1 single byte at top", 32'(mem_wr_data), 32'h0F00);
      chk("R6 half-word waits", 32'(mem_wr_valid), 32'd1);
      go_idle();

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule